// File: doc/BRIEF.md
# Redundant Word Address Remapper

This block sits between a memory's user port and the memory array and repairs individual faulty words. It holds a small table of spare words. Each spare carries a valid bit, the address of a faulty location and a data field that stands in for that location. Every user access compares its address in parallel with all valid spare addresses. A write that hits stores its data in the matching spare. A read that hits returns the spare's data instead of the faulty word coming back from the memory.

User accesses are always passed through to the memory unchanged, so the array behaves as if nothing were in front of it. Faulty addresses are loaded one at a time through a program port. Each one takes a free spare. When the table is full, a sticky overflow flag is raised. Read data leaves the block with the same latency as the memory's own read path, so a hit and a miss are indistinguishable in timing.

Top module: `redword_remap`

## Requirements
- R1: After reset, no spare is valid and `prog_ovf` is 0, so a read of any address returns the memory's read data.
- R2: A read whose address matches no valid spare returns `mem_rdata`, aligned to the read `RD_LAT` clock edges after the access.
- R3: A program request (`prog_en` high for one cycle) for an address not yet stored and with a free spare takes effect from the next cycle: accesses to that address then hit.
- R4: Programming an address that is already stored does not create a second entry. It uses no spare and leaves the stored data unchanged. At most one spare ever matches an address.
- R5: A newly programmed spare's data field starts at zero, so reading it before any write returns 0.
- R6: A write whose address hits a valid spare stores `usr_wdata` into that spare. Later reads of the address return that value, whatever the memory holds.
- R7: Every access is forwarded to the memory in the same cycle: `mem_en`, `mem_we`, `mem_addr` and `mem_wdata` follow the user inputs, including on a write hit.
- R8: A read hit returns the spare's data exactly `RD_LAT` edges after the access, like a miss. Back-to-back reads mixing hits and misses each return their own data in order.
- R9: A program request for a new address when all spares are valid sets `prog_ovf`, which stays set until reset. The address is not repaired and still reads from the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_en | input | 1 | User access valid this cycle |
| usr_we | input | 1 | 1 = write, 0 = read |
| usr_addr | input | AW | User word address |
| usr_wdata | input | DW | User write data |
| usr_rdata | output | DW | Read data, `RD_LAT` cycles after a read |
| mem_en | output | 1 | Access enable to the memory |
| mem_we | output | 1 | Write enable to the memory |
| mem_addr | output | AW | Address to the memory |
| mem_wdata | output | DW | Write data to the memory |
| mem_rdata | input | DW | Memory read data, `RD_LAT` cycles after a read |
| prog_en | input | 1 | Load `prog_addr` as a faulty address |
| prog_addr | input | AW | Faulty address to be repaired |
| prog_ovf | output | 1 | Sticky: a program request found no free spare |

## Verification
The bench builds the block with AW=6, DW=8, NENT=3 and RD_LAT=2. Three spares let the table fill and overflow after a handful of program requests. A two-stage read latency puts two reads in flight at once, so back-to-back hit/miss ordering is exercised. The attached memory model corrupts a few addresses by a fixed XOR pattern, which makes a read served by a spare clearly distinct from one served by the memory.

// File: rtl/redword_remap.sv
module redword_remap #(
  parameter int AW     = 10,
  parameter int DW     = 16,
  parameter int NENT   = 4,
  parameter int RD_LAT = 1,
  localparam int IW    = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          usr_en,
  input  logic          usr_we,
  input  logic [AW-1:0] usr_addr,
  input  logic [DW-1:0] usr_wdata,
  output logic [DW-1:0] usr_rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          prog_en,
  input  logic [AW-1:0] prog_addr,
  output logic          prog_ovf
);

  logic [NENT-1:0] vld;
  logic [AW-1:0]   tag [NENT];
  logic [DW-1:0]   dat [NENT];

  logic [NENT-1:0] hit, dup;
  logic            any_hit, any_dup, have_free;
  logic [IW-1:0]   hit_idx, free_idx;
  logic [DW-1:0]   hit_dat;

  logic            rq_hit [RD_LAT];
  logic [DW-1:0]   rq_dat [RD_LAT];

  assign mem_en    = usr_en;
  assign mem_we    = usr_we;
  assign mem_addr  = usr_addr;
  assign mem_wdata = usr_wdata;

  always_comb begin
    for (int i = 0; i < NENT; i++) begin
      hit[i] = usr_en && vld[i] && (tag[i] == usr_addr);
      dup[i] = vld[i] && (tag[i] == prog_addr);
    end
  end

  assign any_hit = |hit;
  assign any_dup = |dup;

  always_comb begin
    hit_idx   = '0;
    hit_dat   = '0;
    free_idx  = '0;
    have_free = 1'b0;
    for (int i = NENT-1; i >= 0; i--) begin
      if (hit[i]) begin
        hit_idx = IW'(i);
        hit_dat = dat[i];
      end
      if (!vld[i]) begin
        free_idx  = IW'(i);
        have_free = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld      <= '0;
      prog_ovf <= 1'b0;
      for (int i = 0; i < NENT; i++) begin
        tag[i] <= '0;
        dat[i] <= '0;
      end
    end else begin
      if (usr_en && usr_we && any_hit)
        dat[hit_idx] <= usr_wdata;
      if (prog_en && !any_dup) begin
        if (have_free) begin
          vld[free_idx] <= 1'b1;
          tag[free_idx] <= prog_addr;
          dat[free_idx] <= '0;
        end else begin
          prog_ovf <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < RD_LAT; s++) begin
        rq_hit[s] <= 1'b0;
        rq_dat[s] <= '0;
      end
    end else begin
      rq_hit[0] <= usr_en && !usr_we && any_hit;
      rq_dat[0] <= hit_dat;
      for (int s = 1; s < RD_LAT; s++) begin
        rq_hit[s] <= rq_hit[s-1];
        rq_dat[s] <= rq_dat[s-1];
      end
    end
  end

  assign usr_rdata = rq_hit[RD_LAT-1] ? rq_dat[RD_LAT-1] : mem_rdata;

  logic [AW-1:0] chk_pa;
  logic [IW-1:0] chk_idx;
  logic          chk_seen;
  logic [DW-1:0] chk_dat;

  always_ff @(posedge clk) begin
    chk_pa  <= prog_addr;
    chk_idx <= hit_idx;
  end

  always_comb begin
    chk_seen = 1'b0;
    for (int i = 0; i < NENT; i++)
      if (vld[i] && tag[i] == chk_pa) chk_seen = 1'b1;
  end

  assign chk_dat = dat[chk_idx];

  p_prog_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |=> (chk_seen || prog_ovf));

  p_single_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit) && $onehot0(dup));

  p_wr_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_en && usr_we && any_hit) |=> (chk_dat == $past(usr_wdata)));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_ovf) |-> (&vld));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_ovf |=> prog_ovf);

endmodule

// File: tb/redword_remap_tb.sv
module redword_remap_tb_top;
  localparam int AW = 6, DW = 8, NENT = 3, RD_LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic usr_en = 0, usr_we = 0, prog_en = 0;
  logic [AW-1:0] usr_addr = '0, prog_addr = '0;
  logic [DW-1:0] usr_wdata = '0;
  logic [DW-1:0] usr_rdata, mem_wdata, mem_rdata;
  logic mem_en, mem_we, prog_ovf;
  logic [AW-1:0] mem_addr;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  redword_remap #(.AW(AW), .DW(DW), .NENT(NENT), .RD_LAT(RD_LAT)) dut_i (
    .clk, .rst_n, .usr_en, .usr_we, .usr_addr, .usr_wdata, .usr_rdata,
    .mem_en, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
    .prog_en, .prog_addr, .prog_ovf);

  logic [DW-1:0] mem [2**AW];
  logic [DW-1:0] mpipe [RD_LAT];

  function automatic logic is_bad(logic [AW-1:0] a);
    return (a == 5) || (a == 9) || (a == 20);
  endfunction

  initial for (int i = 0; i < 2**AW; i++) mem[i] = '0;

  always @(posedge clk) begin
    if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
    mpipe[0] <= (mem_en && !mem_we) ? (mem[mem_addr] ^ (is_bad(mem_addr) ? 8'hA5 : 8'h00)) : 8'h00;
    for (int s = 1; s < RD_LAT; s++) mpipe[s] <= mpipe[s-1];
  end
  assign mem_rdata = mpipe[RD_LAT-1];

  task automatic check(input logic ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string rq);
    @(negedge clk); usr_en = 1; usr_we = 0; usr_addr = a;
    @(negedge clk); usr_en = 0;
    repeat (RD_LAT-1) @(negedge clk);
    check(usr_rdata === exp, rq, usr_rdata, exp);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); usr_en = 1; usr_we = 1; usr_addr = a; usr_wdata = d;
    @(negedge clk); usr_en = 0; usr_we = 0;
  endtask

  task automatic prog(input logic [AW-1:0] a);
    @(negedge clk); prog_en = 1; prog_addr = a;
    @(negedge clk); prog_en = 0;
  endtask

  task automatic do_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset_state;
    do_reset();
    check(prog_ovf === 1'b0, "R1 ovf after reset", prog_ovf, 0);
    rd(5, 8'hA5, "R1 faulty word unrepaired after reset");
    wr(7, 8'h5A);
    rd(7, 8'h5A, "R2 read miss passes memory data");
  endtask

  task automatic t_program_and_write;
    prog(5);
    rd(5, 8'h00, "R5 fresh spare reads zero");
    @(negedge clk); usr_en = 1; usr_we = 1; usr_addr = 5; usr_wdata = 8'h3C;
    #1;
    check(mem_en === 1 && mem_we === 1 && mem_addr === 5 && mem_wdata === 8'h3C,
          "R7 write hit forwarded to memory", {mem_we, mem_addr, mem_wdata}, {1'b1, 6'd5, 8'h3C});
    @(negedge clk); usr_en = 0; usr_we = 0;
    rd(5, 8'h3C, "R6 write hit stored in spare");
    rd(5, 8'h3C, "R3 programmed address hits");
  endtask

  task automatic t_duplicate;
    prog(5);
    rd(5, 8'h3C, "R4 duplicate program keeps data");
    prog(9);
    prog(12);
    check(prog_ovf === 1'b0, "R4 duplicate used no spare", prog_ovf, 0);
    rd(9, 8'h00, "R5 second spare reads zero");
  endtask

  task automatic t_back_to_back;
    wr(9, 8'h77);
    @(negedge clk); usr_en = 1; usr_we = 0; usr_addr = 9;
    @(negedge clk); usr_addr = 7;
    @(negedge clk); usr_en = 0;
    check(usr_rdata === 8'h77, "R8 first of pair (hit)", usr_rdata, 8'h77);
    @(negedge clk);
    check(usr_rdata === 8'h5A, "R8 second of pair (miss)", usr_rdata, 8'h5A);
  endtask

  task automatic t_overflow;
    prog(20);
    check(prog_ovf === 1'b1, "R9 overflow on full table", prog_ovf, 1);
    wr(20, 8'h11);
    rd(20, 8'hB4, "R9 overflowed address still faulty");
    prog(5);
    repeat (4) @(negedge clk);
    check(prog_ovf === 1'b1, "R9 overflow sticky", prog_ovf, 1);
    rd(5, 8'h3C, "R6 spare intact after overflow");
  endtask

  task automatic t_reset_again;
    do_reset();
    check(prog_ovf === 1'b0, "R1 ovf cleared by reset", prog_ovf, 0);
    rd(5, 8'h99, "R1 spares cleared by reset");
  endtask

  initial begin
    t_reset_state();
    t_program_and_write();
    t_duplicate();
    t_back_to_back();
    t_overflow();
    t_reset_again();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule